// File: doc/BRIEF.md
# Burst-Mode Two-Wire Handshake Sequencer

This block is a clocked controller for a burst-mode protocol over two level inputs and two level outputs. It steps through a closed ring of four phases, A, B, C and D. Each phase has an expected set of input edges, called a burst. The edges of a burst may arrive in any order and may be spread over any number of clock samples. The controller holds its outputs and its phase until every edge of the expected burst has been seen. It then switches both outputs and the phase together, in one clock edge.

The inputs first pass through a parameterised synchronizer chain. After that, the controller compares the sampled pair with the pair that enters the next phase. A register of edges already received catches two kinds of wrong input: an input that reverses before its burst is complete, and an input that moves although it is not part of the current burst. Either one sets a sticky protocol-error flag.

Input pairs below are written {in_a, in_b}. Output pairs are written {out_a, out_b}.

Top module: `burst_hs_ctrl`

## Requirements
- R1: While rst_n is low and after its release, state_code is 00, both outputs are 0 and proto_err is 0.
- R2: In phase A (code 00, inputs 00), once both in_a and in_b have risen (inputs 11), the block enters phase B: state_code 01, outputs 11.
- R3: In phase B (inputs 11), once in_a has fallen (inputs 01), the block enters phase C: state_code 11, outputs 10.
- R4: In phase C (inputs 01), once in_a has risen and in_b has fallen (inputs 10), the block enters phase D: state_code 10, outputs 01.
- R5: In phase D (inputs 10), once in_a has fallen (inputs 00), the block enters phase A: state_code 00, outputs 00.
- R6: While a burst is incomplete, the outputs and state_code do not change, whatever the arrival order and the gaps between edges.
- R7: The outputs and state_code change on the same clock edge, SYNC_STAGES+1 rising edges after the final input edge of the burst is applied.
- R8: With no input change (an empty burst), the phase and the outputs stay as they are.
- R9: A change of an input that is not part of the current burst sets proto_err.
- R10: An input that returns to its phase-entry value after it has changed, before the burst completes, sets proto_err.
- R11: Once set, proto_err stays 1 until reset.
- R12: Every phase change alters exactly one bit of state_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_a | input | 1 | First handshake input |
| in_b | input | 1 | Second handshake input |
| out_a | output | 1 | First handshake output |
| out_b | output | 1 | Second handshake output |
| state_code | output | 2 | Current phase code (A=00, B=01, C=11, D=10) |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The bench builds the block with SYNC_STAGES = 2. This gives a three-edge latency from the last input edge to the output switch, so the bench can confirm that no output moves while the edge sits in the synchronizer chain. It drives each two-edge burst in three ways: in_a first, in_b first, and both together. It also runs laps with random gaps and random orders, so an early switch on a partial burst shows up as an output change that the scoreboard did not expect. Separate runs after reset provoke a foreign edge and a reversed edge, and confirm that the error flag stays set.

// File: rtl/burst_hs_pkg.sv
package burst_hs_pkg;

  // Phase codes: ring order A -> B -> C -> D -> A, one bit flips per step
  typedef enum logic [1:0] {
    PH_A = 2'b00,
    PH_B = 2'b01,
    PH_C = 2'b11,
    PH_D = 2'b10
  } hs_phase_e;

  function automatic hs_phase_e phase_succ(input hs_phase_e p);
    case (p)
      PH_A:    return PH_B;
      PH_B:    return PH_C;
      PH_C:    return PH_D;
      default: return PH_A;
    endcase
  endfunction

  // Input pair {in_a,in_b} with which a phase is entered
  function automatic logic [1:0] phase_in(input hs_phase_e p);
    case (p)
      PH_A:    return 2'b00;
      PH_B:    return 2'b11;
      PH_C:    return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  // Output pair {out_a,out_b} held during a phase
  function automatic logic [1:0] phase_out(input hs_phase_e p);
    case (p)
      PH_A:    return 2'b00;
      PH_B:    return 2'b11;
      PH_C:    return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  // Inputs that belong to the burst leaving phase p
  function automatic logic [1:0] burst_bits(input hs_phase_e p);
    return phase_in(p) ^ phase_in(phase_succ(p));
  endfunction

endpackage

// File: rtl/hs_in_sync.sv
module hs_in_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] chain [STAGES];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hs_burst_tracker.sv
module hs_burst_tracker
  import burst_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  hs_phase_e  phase,
  input  logic [1:0] smp,
  output logic       burst_done,
  output logic       foreign_evt,
  output logic       reverse_evt
);
  logic [1:0] moved;
  logic [1:0] mask;
  logic [1:0] arrived;

  assign mask        = burst_bits(phase);
  assign moved       = smp ^ phase_in(phase);
  assign burst_done  = (smp == phase_in(phase_succ(phase)));
  assign foreign_evt = |(moved & ~mask);
  assign reverse_evt = |(arrived & ~moved);

  always_ff @(posedge clk) begin
    if (!rst_n)          arrived <= '0;
    else if (burst_done) arrived <= '0;
    else                 arrived <= arrived | (moved & mask);
  end
endmodule

// File: rtl/burst_hs_ctrl.sv
module burst_hs_ctrl
  import burst_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_a,
  input  logic       in_b,
  output logic       out_a,
  output logic       out_b,
  output logic [1:0] state_code,
  output logic       proto_err
);
  localparam int NIN = 2;

  logic [NIN-1:0] smp;
  hs_phase_e      phase;
  logic [1:0]     outs;
  logic           err_q;
  logic           burst_done;
  logic           foreign_evt;
  logic           reverse_evt;

  hs_in_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({in_a, in_b}),
    .q     (smp)
  );

  hs_burst_tracker u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .smp         (smp),
    .burst_done  (burst_done),
    .foreign_evt (foreign_evt),
    .reverse_evt (reverse_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_A;
      outs  <= phase_out(PH_A);
      err_q <= 1'b0;
    end else begin
      if (burst_done) begin
        phase <= phase_succ(phase);
        outs  <= phase_out(phase_succ(phase));
      end
      err_q <= err_q | foreign_evt | reverse_evt;
    end
  end

  assign out_a      = outs[1];
  assign out_b      = outs[0];
  assign state_code = phase;
  assign proto_err  = err_q;
endmodule

// File: rtl/burst_hs_chk.sv
module burst_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       burst_done,
  input logic       foreign_evt,
  input logic       reverse_evt,
  input logic       out_a,
  input logic       out_b,
  input logic [1:0] state_code,
  input logic       proto_err
);
  // R6
  hold_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_done |=> ($stable({out_a, out_b}) && $stable(state_code)));

  // R7
  switch_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> (state_code != $past(state_code)));

  // R12
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != $past(state_code)) |->
      ($countones(state_code ^ $past(state_code)) == 1));

  // R9
  foreign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_evt |=> proto_err);

  // R10
  reverse_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reverse_evt |=> proto_err);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind burst_hs_ctrl burst_hs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .burst_done  (burst_done),
  .foreign_evt (foreign_evt),
  .reverse_evt (reverse_evt),
  .out_a       (out_a),
  .out_b       (out_b),
  .state_code  (state_code),
  .proto_err   (proto_err)
);

// File: tb/tb_burst_hs_ctrl.sv
`timescale 1ns/1ps
module tb_burst_hs_ctrl;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cur_in = 2'b00;
  logic       out_a, out_b, proto_err;
  logic [1:0] state_code;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  logic [4:0] exp_q[$];
  logic [4:0] prev_obs = 5'b0;

  always #10 clk = ~clk;

  burst_hs_ctrl #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .in_a(cur_in[1]), .in_b(cur_in[0]),
    .out_a(out_a), .out_b(out_b), .state_code(state_code), .proto_err(proto_err)
  );

  function automatic logic [4:0] obs();
    return {out_a, out_b, state_code, proto_err};
  endfunction

  // Expected values per ring step k (0: A->B, 1: B->C, 2: C->D, 3: D->A)
  function automatic logic [1:0] tgt_in(int k);
    case (k) 0: return 2'b11; 1: return 2'b01; 2: return 2'b10; default: return 2'b00; endcase
  endfunction
  function automatic logic [1:0] tgt_out(int k);
    case (k) 0: return 2'b11; 1: return 2'b10; 2: return 2'b01; default: return 2'b00; endcase
  endfunction
  function automatic logic [1:0] tgt_code(int k);
    case (k) 0: return 2'b01; 1: return 2'b11; 2: return 2'b10; default: return 2'b00; endcase
  endfunction
  function automatic string tgt_req(int k);
    case (k) 0: return "R2"; 1: return "R3"; 2: return "R4"; default: return "R5"; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Scoreboard monitor: every observed change of {outs,code,err} must be expected
  always @(negedge clk) begin
    if (!rst_n) prev_obs <= 5'b0;
    else if (obs() != prev_obs) begin
      if (exp_q.size() == 0) begin
        chk(0, "R6 unexpected change", obs(), prev_obs);
      end else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        chk(obs() == e, "R7 scoreboard", obs(), e);
      end
      prev_obs <= obs();
    end
  end

  task automatic wait_neg(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cur_in = 2'b00;
    wait_neg(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // order: 0 in_a first, 1 in_b first, 2 both together; gap in cycles
  task automatic do_burst(int k, int order, int gap);
    logic [1:0] tgt, diff;
    logic [4:0] old, nxt;
    tgt  = tgt_in(k);
    diff = cur_in ^ tgt;
    old  = obs();
    nxt  = {tgt_out(k), tgt_code(k), 1'b0};
    if (diff == 2'b11 && order != 2) begin
      cur_in = cur_in ^ ((order == 0) ? 2'b10 : 2'b01);
      wait_neg(gap);
      chk(obs() == old, "R6 partial burst", obs(), old);
    end
    exp_q.push_back(nxt);
    cur_in = tgt;
    wait_neg(SYNC - 1);
    chk(obs() == old, "R7 not before latency", obs(), old);
    wait_neg(0);
    wait_neg(1);
    chk(obs() == nxt, {tgt_req(k), " R7 switch"}, obs(), nxt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0;
    wait_neg(1);
    // R1: during reset
    chk(obs() == 5'b0, "R1 in reset", obs(), 5'b0);
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(1);
    chk(obs() == 5'b0, "R1 after release", obs(), 5'b0);

    // Fixed-order laps
    for (int ord = 0; ord < 3; ord++)
      for (int k = 0; k < 4; k++) do_burst(k, ord, 2);

    // Random orders and gaps
    for (int lap = 0; lap < 6; lap++)
      for (int k = 0; k < 4; k++)
        do_burst(k, $urandom_range(0, 2), $urandom_range(0, 6));

    chk(proto_err == 1'b0, "R9 R10 no false error", {4'b0, proto_err}, 5'b0);

    // R8: empty burst in A and in B
    wait_neg(12);
    chk(obs() == 5'b0, "R8 empty burst A", obs(), 5'b0);
    do_burst(0, 2, 0);
    wait_neg(12);
    chk(obs() == 5'b11010, "R8 empty burst B", obs(), 5'b11010);

    // R9: foreign edge in B (in_b falls)
    exp_q.push_back(5'b11011);
    cur_in = 2'b10;
    wait_neg(SYNC + 2);
    chk(obs() == 5'b11011, "R9 foreign edge", obs(), 5'b11011);
    cur_in = 2'b11;
    wait_neg(10);
    chk(proto_err == 1'b1, "R11 sticky", {4'b0, proto_err}, 5'b1);

    // R10: reversal in A
    do_reset();
    chk(obs() == 5'b0, "R1 second reset", obs(), 5'b0);
    cur_in = 2'b10;
    wait_neg(SYNC + 3);
    chk(obs() == 5'b0, "R6 half burst A", obs(), 5'b0);
    exp_q.push_back(5'b00001);
    cur_in = 2'b00;
    wait_neg(SYNC + 2);
    chk(obs() == 5'b00001, "R10 reversal", obs(), 5'b00001);
    wait_neg(8);
    chk(proto_err == 1'b1, "R11 sticky after reversal", {4'b0, proto_err}, 5'b1);

    do_reset();
    chk(obs() == 5'b0, "R11 cleared by reset", obs(), 5'b0);
    chk(exp_q.size() == 0, "R7 all expected switches seen", 5'(exp_q.size()), 5'b0);
    report();
  end
endmodule